// File: doc/BRIEF.md
# Branch Resolution and Interworking Unit

This block resolves one decoded control-transfer operation per clock. The operation kind, a 4-bit condition code, the N/Z/C/V flags, a signed immediate offset, a register operand and the current fetch address are presented together. On the next rising edge the block registers four results: whether the transfer is taken, the next fetch address, whether the link register must be written and with what value, and the instruction-set mode to fetch in next.

Two instruction sets share one address space. One has halfword-aligned encodings and the other has word-aligned encodings. Bit 0 of every code pointer is therefore free, and the block uses it as the mode tag. An indirect branch reads the mode from the low bit of its register operand and clears that bit to form the target. A linking branch folds the current mode into bit 0 of the return address. The block also flags a compare-with-zero branch whose offset cannot be encoded, and a word-mode target that is not word aligned.

Decode, register-file writes and pipeline flush belong to neighbouring blocks.

Top module: `brw_unit`

## Requirements
- R1: All outputs are registered. While `rst_n` is low they read zero: not taken, target 0, no link write, link 0, mode 0, no illegal flag, no fault.
- R2: Condition codes are decoded as pairs, and bits [3:1] select the pair. Pair 0 tests Z=1, pair 1 tests C=1, pair 2 tests N=1 and pair 3 tests V=1. Pair 4 tests C=1 and Z=0. Pair 5 tests N==V. Pair 6 tests Z=0 and N==V. Pair 7 is always true. The flags arrive on `flags` as {N,Z,C,V}, bit 3 down to bit 0.
- R3: For pairs 0 to 6, `cond[0]`=1 negates the test. Codes 14 and 15 are both always taken.
- R4: Operation kind 2 (branch if zero) is taken when the operand is zero. Kind 3 (branch if nonzero) is taken when the operand is nonzero.
- R5: For kinds 2 and 3, a negative offset or an offset above 126 sets `illegal`. The branch is then not taken.
- R6: Kinds 0 (always), 1 (conditional), 2, 3 and 4 (branch-and-link) use the target current address + 4 + offset, modulo 2^32. Kind 0 is always taken.
- R7: Kinds 4 and 6 (indirect with link) assert `link_we`. The link value is the current address plus the instruction length, with bit 0 set to the current mode. All other kinds leave `link_we` low.
- R8: Kinds 5 (indirect) and 6 are always taken. The target is the operand with bit 0 cleared, and the next mode is the operand's bit 0 (1 = halfword set, 0 = word set). When `reg_is_pc` is high, the operand is the current address + 4.
- R9: `align_fault` is set for a kind 5 or 6 whose operand has bit 0 = 0 and bit 1 = 1.
- R10: A branch that is not taken outputs the target current address + 2 (`len4`=0) or + 4 (`len4`=1). Kinds other than 5 and 6 keep the current mode.
- R11: Kind 7 is reserved. It is not taken, sets `illegal` and does not write the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | Operation kind 0..7 |
| cond | input | 4 | Condition code for kind 1 |
| flags | input | 4 | {N,Z,C,V} |
| imm_off | input | 32 | Signed byte offset |
| reg_val | input | 32 | Register operand |
| reg_is_pc | input | 1 | Operand is the program counter |
| cur_pc | input | 32 | Address of the current operation |
| len4 | input | 1 | Current operation is 4 bytes long |
| cur_mode | input | 1 | Current mode, 1 = halfword set |
| taken | output | 1 | Transfer taken |
| target | output | 32 | Next fetch address |
| link_we | output | 1 | Link register write enable |
| link_val | output | 32 | Value for the link register |
| next_mode | output | 1 | Mode for the next fetch |
| illegal | output | 1 | Offset or operation kind not allowed |
| align_fault | output | 1 | Word-mode target not word aligned |

## Verification
An indirect branch with link produces a link write, a mode switch and possibly an alignment fault in the same cycle. The link value must carry the old mode while the new mode comes from the operand. The bench provokes this with directed operands ending in binary 10, 11, 00 and 01, issued from both modes, and with random operands. All seven outputs of each such cycle are compared against a bench model. The bench also crosses the compare-with-zero range check against zero and nonzero operands. It drives offsets of -2, 0, 126 and 128, so that the illegal flag and the taken decision are judged together.

// File: rtl/brw_pkg.sv
package brw_pkg;
   typedef enum logic [2:0] {
      OP_B    = 3'd0,
      OP_BC   = 3'd1,
      OP_CBZ  = 3'd2,
      OP_CBNZ = 3'd3,
      OP_BL   = 3'd4,
      OP_BX   = 3'd5,
      OP_BLX  = 3'd6,
      OP_RSV  = 3'd7
   } brw_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } brw_flags_t;
endpackage

// File: rtl/brw_cond_eval.sv
module brw_cond_eval
   import brw_pkg::*;
(
   input  logic [3:0] cond,
   input  brw_flags_t fl,
   output logic       pass
);
   logic base;

   always_comb begin
      unique case (cond[3:1])
         3'd0:    base = fl.z;
         3'd1:    base = fl.c;
         3'd2:    base = fl.n;
         3'd3:    base = fl.v;
         3'd4:    base = fl.c & ~fl.z;
         3'd5:    base = (fl.n == fl.v);
         3'd6:    base = ~fl.z & (fl.n == fl.v);
         default: base = 1'b1;
      endcase
   end

   // pair 7 has no complement: bit 0 is ignored there
   assign pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
endmodule

// File: rtl/brw_resolve.sv
module brw_resolve
   import brw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int PC_AHEAD    = 4,
   parameter int CBZ_MAX     = 126,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  brw_op_e         op,
   input  logic [3:0]      cond,
   input  brw_flags_t      fl,
   input  logic [AW-1:0]   off,
   input  logic [AW-1:0]   rv,
   input  logic            rv_is_pc,
   input  logic [AW-1:0]   pc,
   input  logic            len4,
   input  logic            mode_in,
   output logic            tk,
   output logic [AW-1:0]   tgt,
   output logic            lwe,
   output logic [AW-1:0]   lval,
   output logic            mode_out,
   output logic            ill,
   output logic            fault
);
   localparam logic [AW-1:0] AHEAD_V = AW'(PC_AHEAD);
   localparam logic [AW-1:0] CBZ_LIM = AW'(CBZ_MAX);
   localparam logic [AW-1:0] LEN_S   = AW'(2);
   localparam logic [AW-1:0] LEN_L   = AW'(4);

   logic            cpass;
   logic [AW-1:0]   fall, ahead, rel, opnd;
   logic            opnd_zero, cbz_bad, indirect, sel_tk;
   logic [AW-1:0]   sel_tgt;

   brw_cond_eval u_cond (
      .cond (cond),
      .fl   (fl),
      .pass (cpass)
   );

   assign fall      = pc + (len4 ? LEN_L : LEN_S);
   assign ahead     = pc + AHEAD_V;
   assign rel       = ahead + off;
   assign opnd      = rv_is_pc ? ahead : rv;
   assign opnd_zero = (opnd == '0);
   assign cbz_bad   = off[AW-1] | (off > CBZ_LIM);
   assign indirect  = (op == OP_BX) || (op == OP_BLX);

   always_comb begin
      sel_tk  = 1'b0;
      sel_tgt = rel;
      lwe     = 1'b0;
      ill     = 1'b0;
      unique case (op)
         OP_B:    sel_tk = 1'b1;
         OP_BC:   sel_tk = cpass;
         OP_CBZ:  begin sel_tk = ~cbz_bad & opnd_zero;  ill = cbz_bad; end
         OP_CBNZ: begin sel_tk = ~cbz_bad & ~opnd_zero; ill = cbz_bad; end
         OP_BL:   begin sel_tk = 1'b1; lwe = 1'b1; end
         OP_BX:   begin sel_tk = 1'b1; sel_tgt = {opnd[AW-1:1], 1'b0}; end
         OP_BLX:  begin sel_tk = 1'b1; lwe = 1'b1; sel_tgt = {opnd[AW-1:1], 1'b0}; end
         default: ill = 1'b1;
      endcase
   end

   assign tk       = sel_tk;
   assign tgt      = sel_tk ? sel_tgt : fall;
   assign lval     = {fall[AW-1:1], mode_in};
   assign mode_out = indirect ? opnd[0] : mode_in;

   generate
      if (ALIGN_CHECK) begin : g_align
         assign fault = indirect & ~opnd[0] & opnd[1];
      end else begin : g_noalign
         assign fault = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/brw_unit.sv
module brw_unit
   import brw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int PC_AHEAD    = 4,
   parameter int CBZ_MAX     = 126,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op_kind,
   input  logic [3:0]    cond,
   input  logic [3:0]    flags,
   input  logic [AW-1:0] imm_off,
   input  logic [AW-1:0] reg_val,
   input  logic          reg_is_pc,
   input  logic [AW-1:0] cur_pc,
   input  logic          len4,
   input  logic          cur_mode,
   output logic          taken,
   output logic [AW-1:0] target,
   output logic          link_we,
   output logic [AW-1:0] link_val,
   output logic          next_mode,
   output logic          illegal,
   output logic          align_fault
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("brw_unit: AW must be at least 8");
      end
      if (CBZ_MAX < 0 || CBZ_MAX >= (1 << (AW - 2))) begin : g_bad_lim
         $error("brw_unit: CBZ_MAX out of range");
      end
   endgenerate

   logic            c_tk, c_lwe, c_mode, c_ill, c_fault;
   logic [AW-1:0]   c_tgt, c_lval;
   logic            vld_q;

   brw_resolve #(
      .AW(AW), .PC_AHEAD(PC_AHEAD), .CBZ_MAX(CBZ_MAX), .ALIGN_CHECK(ALIGN_CHECK)
   ) u_res (
      .op       (brw_op_e'(op_kind)),
      .cond     (cond),
      .fl       (brw_flags_t'(flags)),
      .off      (imm_off),
      .rv       (reg_val),
      .rv_is_pc (reg_is_pc),
      .pc       (cur_pc),
      .len4     (len4),
      .mode_in  (cur_mode),
      .tk       (c_tk),
      .tgt      (c_tgt),
      .lwe      (c_lwe),
      .lval     (c_lval),
      .mode_out (c_mode),
      .ill      (c_ill),
      .fault    (c_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken       <= 1'b0;
         target      <= '0;
         link_we     <= 1'b0;
         link_val    <= '0;
         next_mode   <= 1'b0;
         illegal     <= 1'b0;
         align_fault <= 1'b0;
         vld_q       <= 1'b0;
      end else begin
         taken       <= c_tk;
         target      <= c_tgt;
         link_we     <= c_lwe;
         link_val    <= c_lval;
         next_mode   <= c_mode;
         illegal     <= c_ill;
         align_fault <= c_fault;
         vld_q       <= 1'b1;
      end
   end

   // outputs of a cycle belong to the inputs of the cycle before
   p_al_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(op_kind) == 3'd1 && $past(cond[3:1]) == 3'd7) |-> taken);

   p_cbz_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && ($past(op_kind) == 3'd2 || $past(op_kind) == 3'd3) &&
       ($past(imm_off[AW-1]) || $past(imm_off) > AW'(CBZ_MAX)))
      |-> (!taken && illegal));

   p_link_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && link_we) |-> ($past(op_kind) == 3'd4 || $past(op_kind) == 3'd6));

   p_link_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && link_we) |-> (link_val[0] == $past(cur_mode)));

   p_ind_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && ($past(op_kind) == 3'd5 || $past(op_kind) == 3'd6))
      |-> (taken && !target[0]));

   p_fault_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && align_fault) |-> (!next_mode && target[1]));

   p_fallthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !taken) |-> (target == $past(cur_pc) + ($past(len4) ? AW'(4) : AW'(2))));

   p_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(op_kind) == 3'd7) |-> (illegal && !taken && !link_we));
endmodule

// File: tb/sim_brw_unit.sv
`timescale 1ns/1ps
module sim_brw_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_kind = '0;
   logic [3:0]  cond = '0;
   logic [3:0]  flags = '0;
   logic [31:0] imm_off = '0;
   logic [31:0] reg_val = '0;
   logic        reg_is_pc = 1'b0;
   logic [31:0] cur_pc = '0;
   logic        len4 = 1'b0;
   logic        cur_mode = 1'b0;
   logic        taken, link_we, next_mode, illegal, align_fault;
   logic [31:0] target, link_val;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   brw_unit u0 (.*);

   typedef struct packed {
      logic        tk;
      logic [31:0] tgt;
      logic        lwe;
      logic [31:0] lval;
      logic        md;
      logic        ill;
      logic        flt;
   } exp_t;

   function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
      logic n, z, cy, v, b;
      {n, z, cy, v} = f;
      case (c[3:1])
         3'd0: b = z;
         3'd1: b = cy;
         3'd2: b = n;
         3'd3: b = v;
         3'd4: b = cy && !z;
         3'd5: b = (n == v);
         3'd6: b = !z && (n == v);
         default: return 1'b1;
      endcase
      return c[0] ? !b : b;
   endfunction

   function automatic exp_t model();
      exp_t e;
      logic [31:0] nxt, opnd, rel;
      logic bad;
      nxt  = cur_pc + (len4 ? 32'd4 : 32'd2);
      rel  = cur_pc + 32'd4 + imm_off;
      opnd = reg_is_pc ? cur_pc + 32'd4 : reg_val;
      bad  = ($signed(imm_off) < 0) || ($signed(imm_off) > 126);
      e = '0;
      e.md = cur_mode;
      e.lval = {nxt[31:1], cur_mode};
      case (op_kind)
         3'd0: begin e.tk = 1; e.tgt = rel; end
         3'd1: begin e.tk = cond_ok(cond, flags); e.tgt = rel; end
         3'd2: begin e.ill = bad; e.tk = !bad && opnd == 0; e.tgt = rel; end
         3'd3: begin e.ill = bad; e.tk = !bad && opnd != 0; e.tgt = rel; end
         3'd4: begin e.tk = 1; e.tgt = rel; e.lwe = 1; end
         3'd5, 3'd6: begin
            e.tk = 1; e.tgt = opnd & ~32'd1; e.md = opnd[0];
            e.flt = !opnd[0] && opnd[1];
            e.lwe = (op_kind == 3'd6);
         end
         default: e.ill = 1;
      endcase
      if (!e.tk) e.tgt = nxt;
      return e;
   endfunction

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd0: return "R6";
         3'd1: return "R2 R3";
         3'd2, 3'd3: return "R4 R5";
         3'd4: return "R7";
         3'd5: return "R8 R9";
         3'd6: return "R7 R8 R9";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] k, input logic [3:0] c, input logic [3:0] f,
                        input logic [31:0] off, input logic [31:0] rv, input logic rp,
                        input logic [31:0] pc, input logic l4, input logic md);
      exp_t e;
      @(negedge clk);
      op_kind = k; cond = c; flags = f; imm_off = off; reg_val = rv;
      reg_is_pc = rp; cur_pc = pc; len4 = l4; cur_mode = md;
      e = model();
      @(posedge clk);
      @(negedge clk);
      check(tag_of(k), {63'd0, taken, target},
            {63'd0, e.tk, e.tgt});
      check({tag_of(k), " R10"}, {93'd0, link_we, next_mode, align_fault},
            {93'd0, e.lwe, e.md, e.flt});
      check({tag_of(k), " R7"}, {63'd0, illegal, link_val},
            {63'd0, e.ill, e.lwe ? e.lval : link_val});
   endtask

   initial begin : watchdog
      #500000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", {57'd0, taken, link_we, next_mode, illegal, align_fault, target, link_val[31:0]}, '0);
      rst_n = 1'b1;

      // R2 R3: every code over every flag combination
      for (int cc = 0; cc < 16; cc++)
         for (int ff = 0; ff < 16; ff++)
            apply(3'd1, cc[3:0], ff[3:0], 32'h40, 0, 0, 32'h1000, 1, 1);
      // R4 R5 boundaries
      apply(3'd2, 0, 0, 32'd126, 0, 0, 32'h200, 0, 1);
      apply(3'd2, 0, 0, 32'd128, 0, 0, 32'h200, 0, 1);
      apply(3'd3, 0, 0, 32'hFFFF_FFFE, 5, 0, 32'h200, 0, 1);
      apply(3'd3, 0, 0, 32'd0, 5, 0, 32'h200, 1, 1);
      apply(3'd2, 0, 0, 32'd4, 7, 0, 32'h200, 0, 1);
      // R6 wrap
      apply(3'd0, 0, 0, 32'h20, 0, 0, 32'hFFFF_FFF0, 1, 1);
      apply(3'd4, 0, 0, 32'hFFFF_F000, 0, 0, 32'h100, 1, 0);
      // R7 R8 R9: link, mode switch and fault together
      apply(3'd6, 0, 0, 0, 32'h0000_1002, 0, 32'h400, 0, 1);
      apply(3'd6, 0, 0, 0, 32'h0000_1003, 0, 32'h400, 1, 0);
      apply(3'd6, 0, 0, 0, 32'h0000_1000, 0, 32'h400, 0, 1);
      apply(3'd5, 0, 0, 0, 32'h0000_1001, 0, 32'h400, 0, 0);
      apply(3'd5, 0, 0, 0, 32'hDEAD_BEEF, 1, 32'h0000_0802, 0, 1);
      apply(3'd5, 0, 0, 0, 0, 1, 32'h0000_0806, 0, 1);
      // R11
      apply(3'd7, 0, 0, 0, 0, 0, 32'h300, 1, 1);

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] off, rv;
         off = ($urandom % 3 == 0) ? 32'($signed($urandom % 160) - 20) : $urandom;
         rv  = ($urandom % 4 == 0) ? 32'd0 : $urandom;
         apply($urandom % 8, $urandom % 16, $urandom % 16, off, rv,
               ($urandom % 8 == 0), $urandom & ~32'd1, $urandom % 2, $urandom % 2);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule